// File: doc/BRIEF.md
# Sync Header Error-Rate Supervisor

This block watches the 2-bit synchronization headers of a 64b/66b receive path once the path has found block lock. It counts invalid headers over back-to-back windows of a fixed number of clock cycles. When a window closes, it raises a high-error-rate flag if that window held more invalid headers than a set limit, and clears the flag if it did not. A link layer above it uses the flag to decide when to stop trusting received data.

Two status counters run next to the window logic. One counts every invalid header seen while locked, which is each entry into the bad-header state. The other counts entries into the receive-error state of the decoder. Both counters stop at full scale and return to zero on a clear strobe. The window length is given in clock cycles. For a 125 µs window it is 125 µs multiplied by the clock frequency, and a bench can shorten it.

Top module: `hdr_err_supervisor`

## Requirements
- R1: During reset and right after it, `hi_ber` is 0 and both event counters are 0.
- R2: A window is `WIN_CYCLES` consecutive clock edges with `blk_lock` high. The first window starts at the first edge where lock is high. An invalid header sampled on the closing edge of a window counts toward that window.
- R3: On a window's closing edge, `hi_ber` becomes 1 if the window held more than `BAD_LIMIT` invalid headers. A count of exactly `BAD_LIMIT` leaves it 0. The new value is visible after that edge.
- R4: On a window's closing edge with `BAD_LIMIT` or fewer invalid headers, `hi_ber` becomes 0. Between closing edges `hi_ber` does not change while lock stays high.
- R5: The per-window count restarts at zero for every window, so invalid headers never carry over into the next window.
- R6: While `blk_lock` is 0, `hi_ber` reads 0 in that same cycle. Both the window and the stored flag are reset, so the next window starts fresh when lock returns.
- R7: An invalid header is a cycle with `hdr_vld`=1, `hdr_bad`=1 and `blk_lock`=1. Each one raises `bad_evt_cnt` by 1. `hdr_bad` without `hdr_vld`, and any header seen while unlocked, changes nothing.
- R8: Each cycle with `rxe_enter`=1 raises `rxe_evt_cnt` by 1, whatever the state of lock.
- R9: With the default saturating mode, each event counter holds at 2^`CNT_W`−1 instead of wrapping.
- R10: `stat_clr`=1 sets both event counters to 0 on the next edge, even when an event arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_lock | input | 1 | Block lock achieved |
| hdr_vld | input | 1 | A block header is present this cycle |
| hdr_bad | input | 1 | The present header is invalid (qualified by hdr_vld) |
| rxe_enter | input | 1 | Pulse on entry into the receive-error state |
| stat_clr | input | 1 | Clear both event counters |
| hi_ber | output | 1 | High error rate flag |
| bad_evt_cnt | output | CNT_W | Count of invalid headers seen while locked |
| rxe_evt_cnt | output | CNT_W | Count of receive-error state entries |

## Verification
A window's verdict is due one edge after its closing edge. The event counters move one edge after the event or clear. `hi_ber` falls in the same cycle that lock drops, with no register delay. The bench drives inputs on the falling edge and advances its own model on the rising edge. It then compares all three outputs at the next falling edge, so each result is checked in the exact cycle it is due. Directed windows place the seventeenth invalid header on the closing edge and also test exactly sixteen, so an off-by-one error in the window length or the limit shows up.

// File: rtl/shber_pkg.sv
package shber_pkg;

   typedef enum logic {
      EVT_WRAP     = 1'b0,
      EVT_SATURATE = 1'b1
   } evt_mode_e;

   // bits needed to hold values 0..maxval
   function automatic int unsigned bits_for(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/shber_win_timer.sv
module shber_win_timer import shber_pkg::*; #(
   parameter int unsigned WIN_CYCLES = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic win_end
);
   localparam int unsigned TW = bits_for(WIN_CYCLES - 1);
   localparam logic [TW-1:0] LAST = TW'(WIN_CYCLES - 1);

   logic [TW-1:0] pos;

   assign win_end = run && (pos == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)                pos <= '0;
      else if (!run || win_end)  pos <= '0;
      else                       pos <= pos + 1'b1;
   end
endmodule

// File: rtl/shber_win_judge.sv
module shber_win_judge import shber_pkg::*; #(
   parameter int unsigned BAD_LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic bad_hit,
   input  logic win_end,
   output logic flag
);
   localparam int unsigned CAP = BAD_LIMIT + 1;
   localparam int unsigned BW  = bits_for(CAP);

   logic [BW-1:0] tally, tally_nxt;
   logic          over;

   // count stops once past the limit; the verdict is already known
   assign tally_nxt = (bad_hit && tally != BW'(CAP)) ? tally + 1'b1 : tally;
   assign over      = tally_nxt > BW'(BAD_LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tally <= '0;
         flag  <= 1'b0;
      end else if (!run) begin
         tally <= '0;
         flag  <= 1'b0;
      end else if (win_end) begin
         tally <= '0;
         flag  <= over;
      end else begin
         tally <= tally_nxt;
      end
   end
endmodule

// File: rtl/shber_evt_counter.sv
module shber_evt_counter import shber_pkg::*; #(
   parameter int unsigned W    = 16,
   parameter evt_mode_e   MODE = EVT_SATURATE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         hit,
   output logic [W-1:0] count
);
   logic bump;

   generate
      if (W < 1) begin : g_bad_width
         $error("shber_evt_counter: W must be at least 1");
      end
      if (MODE == EVT_SATURATE) begin : g_sat
         assign bump = hit && (count != {W{1'b1}});
      end else begin : g_wrap
         assign bump = hit;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     count <= '0;
      else if (clr)   count <= '0;
      else if (bump)  count <= count + 1'b1;
   end
endmodule

// File: rtl/hdr_err_supervisor.sv
module hdr_err_supervisor import shber_pkg::*; #(
   parameter int unsigned WIN_CYCLES = 20000,
   parameter int unsigned BAD_LIMIT  = 16,
   parameter int unsigned CNT_W      = 16,
   parameter evt_mode_e   EVT_MODE   = EVT_SATURATE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blk_lock,
   input  logic             hdr_vld,
   input  logic             hdr_bad,
   input  logic             rxe_enter,
   input  logic             stat_clr,
   output logic             hi_ber,
   output logic [CNT_W-1:0] bad_evt_cnt,
   output logic [CNT_W-1:0] rxe_evt_cnt
);
   generate
      if (WIN_CYCLES < 2) begin : g_chk_win
         $error("hdr_err_supervisor: WIN_CYCLES must be at least 2");
      end
      if (BAD_LIMIT < 1) begin : g_chk_lim
         $error("hdr_err_supervisor: BAD_LIMIT must be at least 1");
      end
      if (CNT_W < 2) begin : g_chk_cw
         $error("hdr_err_supervisor: CNT_W must be at least 2");
      end
   endgenerate

   logic bad_hit;
   logic win_end;
   logic flag_q;

   assign bad_hit = blk_lock && hdr_vld && hdr_bad;

   shber_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (blk_lock),
      .win_end (win_end)
   );

   shber_win_judge #(.BAD_LIMIT(BAD_LIMIT)) u_judge (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (blk_lock),
      .bad_hit (bad_hit),
      .win_end (win_end),
      .flag    (flag_q)
   );

   // losing lock silences the flag in the same cycle
   assign hi_ber = flag_q && blk_lock;

   shber_evt_counter #(.W(CNT_W), .MODE(EVT_MODE)) u_bad_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (stat_clr),
      .hit   (bad_hit),
      .count (bad_evt_cnt)
   );

   shber_evt_counter #(.W(CNT_W), .MODE(EVT_MODE)) u_rxe_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (stat_clr),
      .hit   (rxe_enter),
      .count (rxe_evt_cnt)
   );
endmodule

// File: rtl/hdr_err_supervisor_chk.sv
module hdr_err_supervisor_chk #(
   parameter int unsigned CNT_W = 16,
   parameter bit          SAT   = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             blk_lock,
   input logic             hdr_vld,
   input logic             hdr_bad,
   input logic             rxe_enter,
   input logic             stat_clr,
   input logic             hi_ber,
   input logic [CNT_W-1:0] bad_evt_cnt,
   input logic [CNT_W-1:0] rxe_evt_cnt,
   input logic             win_end
);
   // R6
   hi_ber_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_lock |-> !hi_ber);

   // R4
   hi_ber_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_lock && $past(blk_lock) && !$past(win_end)) |-> $stable(hi_ber));

   // R3
   hi_ber_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_ber) |-> $past(win_end));

   // R10
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr |=> (bad_evt_cnt == '0 && rxe_evt_cnt == '0));

   // R7
   bad_evt_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_clr && !(blk_lock && hdr_vld && hdr_bad)) |=> $stable(bad_evt_cnt));

   // R7
   bad_evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_clr |=> (bad_evt_cnt == $past(bad_evt_cnt) ||
                     bad_evt_cnt == CNT_W'($past(bad_evt_cnt) + 1'b1)));

   // R8
   rxe_evt_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_clr && !rxe_enter) |=> $stable(rxe_evt_cnt));

   generate
      if (SAT) begin : g_sat_chk
         // R9
         bad_evt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bad_evt_cnt == {CNT_W{1'b1}} && !stat_clr) |=> bad_evt_cnt == {CNT_W{1'b1}});
         // R9
         rxe_evt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rxe_evt_cnt == {CNT_W{1'b1}} && !stat_clr) |=> rxe_evt_cnt == {CNT_W{1'b1}});
      end
   endgenerate
endmodule

bind hdr_err_supervisor hdr_err_supervisor_chk #(
   .CNT_W (CNT_W),
   .SAT   (EVT_MODE == shber_pkg::EVT_SATURATE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .blk_lock    (blk_lock),
   .hdr_vld     (hdr_vld),
   .hdr_bad     (hdr_bad),
   .rxe_enter   (rxe_enter),
   .stat_clr    (stat_clr),
   .hi_ber      (hi_ber),
   .bad_evt_cnt (bad_evt_cnt),
   .rxe_evt_cnt (rxe_evt_cnt),
   .win_end     (win_end)
);

// File: tb/hdr_err_supervisor_test.sv
module hdr_err_supervisor_test;
   localparam int unsigned W     = 64;
   localparam int unsigned LIMIT = 16;
   localparam int unsigned CW    = 6;
   localparam int unsigned MAXC  = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic blk_lock = 1'b0, hdr_vld = 1'b0, hdr_bad = 1'b0, rxe_enter = 1'b0, stat_clr = 1'b0;
   logic hi_ber;
   logic [CW-1:0] bad_evt_cnt, rxe_evt_cnt;

   int checks = 0;
   int fails  = 0;
   string cur_req = "R1";

   // reference state, advanced on each rising edge
   int  m_win = 0;
   int  m_bad = 0;
   bit  m_hi  = 0;
   int  m_bev = 0;
   int  m_rxe = 0;

   always #2.5 clk = ~clk;

   hdr_err_supervisor #(
      .WIN_CYCLES (W),
      .BAD_LIMIT  (LIMIT),
      .CNT_W      (CW)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .blk_lock    (blk_lock),
      .hdr_vld     (hdr_vld),
      .hdr_bad     (hdr_bad),
      .rxe_enter   (rxe_enter),
      .stat_clr    (stat_clr),
      .hi_ber      (hi_ber),
      .bad_evt_cnt (bad_evt_cnt),
      .rxe_evt_cnt (rxe_evt_cnt)
   );

   function automatic bit verdict(input int nbad);
      return nbad > LIMIT;
   endfunction

   function automatic int sat_up(input int v, input bit hit);
      return (hit && v < MAXC) ? v + 1 : v;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_edge(input bit l, input bit v, input bit b, input bit r, input bit c);
      bit hit;
      hit = l && v && b;
      if (l) begin
         if (m_win == W - 1) begin
            m_hi  = verdict(m_bad + (hit ? 1 : 0));
            m_bad = 0;
            m_win = 0;
         end else begin
            m_bad = m_bad + (hit ? 1 : 0);
            m_win = m_win + 1;
         end
      end else begin
         m_win = 0;
         m_bad = 0;
         m_hi  = 0;
      end
      if (c) begin
         m_bev = 0;
         m_rxe = 0;
      end else begin
         m_bev = sat_up(m_bev, hit);
         m_rxe = sat_up(m_rxe, r);
      end
   endtask

   // called at a falling edge; returns at the next falling edge after checking
   task automatic tick(input bit l, input bit v, input bit b, input bit r, input bit c);
      blk_lock = l; hdr_vld = v; hdr_bad = b; rxe_enter = r; stat_clr = c;
      @(posedge clk);
      model_edge(l, v, b, r, c);
      @(negedge clk);
      check(cur_req, "hi_ber", int'(hi_ber), int'(m_hi && l));
      check(cur_req, "bad_evt_cnt", int'(bad_evt_cnt), m_bev);
      check(cur_req, "rxe_evt_cnt", int'(rxe_evt_cnt), m_rxe);
   endtask

   // one full window with n invalid headers packed at its end
   task automatic window_with(input int n);
      for (int i = 0; i < W; i++)
         tick(1'b1, 1'b1, (i >= W - n), 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : stimulus
      int unsigned seed_sink;
      int p;
      seed_sink = $urandom(32'd20515);
      repeat (4) @(negedge clk);
      // R1 reset values
      check("R1", "hi_ber in reset", int'(hi_ber), 0);
      check("R1", "bad_evt_cnt in reset", int'(bad_evt_cnt), 0);
      check("R1", "rxe_evt_cnt in reset", int'(rxe_evt_cnt), 0);
      rst_n = 1'b1;
      cur_req = "R1";
      tick(0, 0, 0, 0, 0);

      // R3 exactly the limit stays low, limit+1 with last one on the closing edge goes high (R2)
      cur_req = "R3";
      window_with(LIMIT);
      check("R3", "hi_ber after exactly limit", int'(hi_ber), 0);
      cur_req = "R2";
      window_with(LIMIT + 1);
      check("R2", "hi_ber with bad on closing edge", int'(hi_ber), 1);
      // R4 flag holds through the next window, then clears
      cur_req = "R4";
      for (int i = 0; i < W - 1; i++) tick(1, 0, 0, 0, 0);
      check("R4", "hi_ber held before closing edge", int'(hi_ber), 1);
      tick(1, 0, 0, 0, 0);
      check("R4", "hi_ber after clean window", int'(hi_ber), 0);

      // R5 ten bad at end of one window plus ten at start of next: no carry-over
      cur_req = "R5";
      window_with(10);
      for (int i = 0; i < W; i++) tick(1, 1, (i < 10), 0, 0);
      check("R5", "hi_ber split burst", int'(hi_ber), 0);

      // R7 hdr_bad without hdr_vld is ignored
      cur_req = "R7";
      for (int i = 0; i < 8; i++) tick(1, 0, 1, 0, 0);
      check("R7", "bad_evt_cnt with hdr_vld low", int'(bad_evt_cnt), m_bev);

      // R6 raise the flag, then drop lock mid-window
      cur_req = "R6";
      while (m_win != 0) tick(1, 0, 0, 0, 0);
      window_with(30);
      check("R6", "hi_ber raised before unlock", int'(hi_ber), 1);
      tick(1, 0, 0, 0, 0);
      blk_lock = 1'b0;
      #0.1;
      check("R6", "hi_ber same cycle as unlock", int'(hi_ber), 0);
      for (int i = 0; i < 5; i++) tick(0, 1, 1, 1, 0);   // unlocked bad headers: R7 ignored
      check("R7", "bad_evt_cnt while unlocked", int'(bad_evt_cnt), m_bev);
      check("R8", "rxe_evt_cnt while unlocked", int'(rxe_evt_cnt), m_rxe);
      window_with(0);
      check("R6", "hi_ber after relock clean window", int'(hi_ber), 0);

      // random windows with varying error density
      cur_req = "R8";
      for (int w = 0; w < 40; w++) begin
         case ($urandom % 4)
            0: p = 5;
            1: p = 45;
            2: p = 55;
            default: p = 80;
         endcase
         for (int i = 0; i < W; i++)
            tick(($urandom % 100) < 98, $urandom % 2, ($urandom % 100) < p,
                 ($urandom % 100) < 5, ($urandom % 100) < 1);
      end

      // R9 saturation of both counters
      cur_req = "R9";
      tick(1, 0, 0, 0, 1);
      for (int i = 0; i < int'(MAXC) + 8; i++) tick(1, 1, 1, 1, 0);
      check("R9", "bad_evt_cnt saturated", int'(bad_evt_cnt), MAXC);
      check("R9", "rxe_evt_cnt saturated", int'(rxe_evt_cnt), MAXC);

      // R10 clear wins over a same-cycle event
      cur_req = "R10";
      tick(1, 1, 1, 1, 1);
      check("R10", "bad_evt_cnt after clear", int'(bad_evt_cnt), 0);
      check("R10", "rxe_evt_cnt after clear", int'(rxe_evt_cnt), 0);
      tick(1, 1, 1, 1, 0);
      check("R10", "bad_evt_cnt counts after clear", int'(bad_evt_cnt), 1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule